// File: doc/BRIEF.md
# Watchdog Timer with Paired Clear

This block is the watchdog of a small microcontroller core. A tick source, fixed by a strap, is either the system clock divided by four or pulses from a separate watchdog oscillator. The ticks advance a 7-bit prescaler. An 8-way selector picks one of its taps, and that tap advances an 8-bit counter. When the counter wraps, the watchdog has expired. If the core is running, it gets a one-cycle chip-reset request and a sticky expiry bit is set. If the core is powered down, it gets only a one-cycle wake-up request, which restarts the program counter and stack pointer.

Software keeps the watchdog quiet by issuing clear instructions, which reach the block as single-cycle strobes. A second strap picks the clear style. In single style, one instruction clears the timer. In paired style, two different instructions must both arrive, in either order. Each one is remembered in its own flag, and a repeat of the one already seen changes nothing. The external reset and the halt instruction also restart the timer.

All logic runs on the system clock. The oscillator pulses arrive as a clock-enable that is already synchronous to it.

Top module: `wdog_core`

## Requirements
- R1: While `rst_n` is low, `chip_rst_req`, `wake_rst_req` and `to_flag` are 0. This also applies when reset is applied in mid-run. The first expiry comes a full period after `rst_n` rises.
- R2: With `src_sel`=1, each cycle in which `osc_tick` is 1 is one tick. The counter steps once every 2^k ticks, where k = `per_sel` (0..7). Expiry comes on the 256·2^k-th tick after a clear.
- R3: With `src_sel`=0, a tick occurs every fourth clock cycle, counted from a clear. Expiry comes 1024·2^k cycles after the clear.
- R4: An expiry with `pdown`=0 raises `chip_rst_req` for exactly one cycle and sets `to_flag` in that same cycle. `wake_rst_req` stays 0.
- R5: An expiry with `pdown`=1 raises `wake_rst_req` for exactly one cycle and leaves `chip_rst_req` at 0. `to_flag` keeps its value.
- R6: `to_flag` stays at 1 until reset, a completed software clear or a halt.
- R7: With `pair_mode`=0, a `clr_one` strobe clears the divider, prescaler and counter in the clock edge where it is sampled, so a full period starts again. In this style `clr_a` and `clr_b` have no effect.
- R8: With `pair_mode`=1, a clear takes place only once both `clr_a` and `clr_b` have been seen, in either order or in the same cycle. It takes effect in the edge of the later strobe, and both flags then return to 0. In this style `clr_one` has no effect.
- R9: With `pair_mode`=1, repeating the strobe already recorded, with no other strobe in between, leaves the timer counting.
- R10: `halt` clears the timer and drops both pair flags, so a later lone strobe of the other kind does not clear.
- R11: A clear sampled in the same edge as an expiry wins. No request is raised, and a full period starts again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low external and power-on reset, asynchronous |
| osc_tick | input | 1 | Watchdog-oscillator tick enable, synchronous to clk |
| src_sel | input | 1 | Strap: 0 = system clock / 4, 1 = oscillator ticks |
| pair_mode | input | 1 | Strap: 0 = single-instruction clear, 1 = paired clear |
| clr_one | input | 1 | Strobe from the single clear instruction |
| clr_a | input | 1 | Strobe from the first paired clear instruction |
| clr_b | input | 1 | Strobe from the second paired clear instruction |
| halt | input | 1 | Strobe from the halt instruction |
| pdown | input | 1 | Core is in power-down |
| per_sel | input | 3 | Prescaler tap select, period 2^per_sel ticks per count |
| chip_rst_req | output | 1 | One-cycle full chip-reset request |
| wake_rst_req | output | 1 | One-cycle PC/SP wake-up reset request |
| to_flag | output | 1 | Sticky expiry status |

## Verification
Every tap setting is swept using oscillator ticks, and two settings using the divided clock. The expiry cycle is computed as 256·2^k ticks after the clear edge. A tap selector off by one stage would land at twice or half that cycle, and a divider that is not restarted by a clear would miss it by up to three cycles. In paired style, the bench repeats each instruction alone, then sends both in each order and in the same cycle, then interposes a halt. A design that cleared on a repeat, or that kept a flag across a halt, would expire late. The bench also lands a clear exactly on the expiry edge, and lets an expiry occur during power-down. Getting the first wrong shows up as a stray request. Getting the second wrong shows up as a full chip reset, or as a changed status bit.

// File: rtl/wdog_pkg.sv
`timescale 1ns/1ps
package wdog_pkg;

    typedef enum logic {
        SRC_SYSDIV = 1'b0,
        SRC_OSC    = 1'b1
    } src_e;

    typedef enum logic {
        CLR_SINGLE = 1'b0,
        CLR_PAIRED = 1'b1
    } clr_mode_e;

    typedef struct packed {
        logic chip;
        logic wake;
        logic to;
    } wd_stat_t;

endpackage

// File: rtl/wdog_tick_src.sv
`timescale 1ns/1ps
module wdog_tick_src #(
    parameter int DIV_W = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic src_sel,
    input  logic osc_tick,
    output logic tick
);
    import wdog_pkg::*;

    typedef struct packed {
        logic [DIV_W-1:0] div;
    } tick_st_t;

    tick_st_t st_d, st_q;
    src_e     src;

    always_comb begin
        src     = src_e'(src_sel);
        st_d    = st_q;
        st_d.div = clr ? '0 : st_q.div + 1'b1;
        if (src == SRC_OSC) begin
            tick = osc_tick;
        end else begin
            tick = &st_q.div;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    AST_DIV_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (st_q.div == '0)) else $error("divider not restarted"); // R3

endmodule

// File: rtl/wdog_clear_ctl.sv
`timescale 1ns/1ps
module wdog_clear_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic pair_mode,
    input  logic clr_one,
    input  logic clr_a,
    input  logic clr_b,
    input  logic halt,
    output logic clr_sw
);
    import wdog_pkg::*;

    typedef struct packed {
        logic seen_a;
        logic seen_b;
    } pair_st_t;

    pair_st_t  st_d, st_q;
    clr_mode_e mode;
    logic      hit_a, hit_b, pair_done;

    always_comb begin
        mode      = clr_mode_e'(pair_mode);
        st_d      = st_q;
        hit_a     = clr_a | st_q.seen_a;
        hit_b     = clr_b | st_q.seen_b;
        pair_done = (clr_a | clr_b) & hit_a & hit_b;
        if (mode == CLR_SINGLE) begin
            clr_sw = clr_one;
            st_d   = '0;
        end else begin
            clr_sw = pair_done;
            if (halt || pair_done) begin
                st_d = '0;
            end else begin
                st_d.seen_a = hit_a;
                st_d.seen_b = hit_b;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(st_q.seen_a && st_q.seen_b)) else $error("both pair flags held"); // R8

    AST_SINGLE_NO_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        !pair_mode |=> (!st_q.seen_a && !st_q.seen_b)) else $error("flag in single style"); // R7

    AST_HALT_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        halt |=> (!st_q.seen_a && !st_q.seen_b)) else $error("flag survived halt"); // R10

    AST_REPEAT_A_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (pair_mode && $past(pair_mode) && $past(clr_a) && !$past(clr_b) && !$past(halt)
         && clr_a && !clr_b) |-> !clr_sw) else $error("repeat cleared"); // R9

endmodule

// File: rtl/wdog_div_chain.sv
`timescale 1ns/1ps
module wdog_div_chain #(
    parameter  int PRE_W = 7,
    parameter  int CNT_W = 8,
    localparam int SEL_W = $clog2(PRE_W + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             tick,
    input  logic [SEL_W-1:0] sel,
    output logic             ovf
);
    typedef struct packed {
        logic [PRE_W-1:0] pre;
        logic [CNT_W-1:0] cnt;
    } chain_st_t;

    chain_st_t    st_d, st_q;
    logic [PRE_W:0] stage_hit;
    logic         step;

    assign stage_hit[0] = 1'b1;
    for (genvar i = 1; i <= PRE_W; i++) begin : g_tap
        assign stage_hit[i] = &st_q.pre[i-1:0];
    end

    always_comb begin
        st_d = st_q;
        step = tick & stage_hit[sel];
        ovf  = 1'b0;
        if (clr) begin
            st_d = '0;
        end else if (tick) begin
            st_d.pre = st_q.pre + 1'b1;
            if (step) begin
                st_d.cnt = st_q.cnt + 1'b1;
                ovf      = &st_q.cnt;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    AST_CLR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (st_q.cnt == '0 && st_q.pre == '0)) else $error("clear missed"); // R7

    AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !tick) |=> $stable(st_q.cnt)) else $error("count moved without tick"); // R2

    AST_OVF_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> (st_q.cnt == '0)) else $error("no wrap after expiry"); // R2

endmodule

// File: rtl/wdog_core.sv
`timescale 1ns/1ps
module wdog_core #(
    parameter  int PRE_W = 7,
    parameter  int CNT_W = 8,
    parameter  int DIV_W = 2,
    localparam int SEL_W = $clog2(PRE_W + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             osc_tick,
    input  logic             src_sel,
    input  logic             pair_mode,
    input  logic             clr_one,
    input  logic             clr_a,
    input  logic             clr_b,
    input  logic             halt,
    input  logic             pdown,
    input  logic [SEL_W-1:0] per_sel,
    output logic             chip_rst_req,
    output logic             wake_rst_req,
    output logic             to_flag
);
    import wdog_pkg::*;

    wd_stat_t st_d, st_q;
    logic     clr_sw, clr_any, tick, ovf;

    assign clr_any = clr_sw | halt;

    wdog_clear_ctl u_clr (
        .clk       (clk),
        .rst_n     (rst_n),
        .pair_mode (pair_mode),
        .clr_one   (clr_one),
        .clr_a     (clr_a),
        .clr_b     (clr_b),
        .halt      (halt),
        .clr_sw    (clr_sw)
    );

    wdog_tick_src #(.DIV_W(DIV_W)) u_tick (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr_any),
        .src_sel  (src_sel),
        .osc_tick (osc_tick),
        .tick     (tick)
    );

    wdog_div_chain #(.PRE_W(PRE_W), .CNT_W(CNT_W)) u_chain (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr_any),
        .tick  (tick),
        .sel   (per_sel),
        .ovf   (ovf)
    );

    always_comb begin
        st_d      = st_q;
        st_d.chip = ovf & ~pdown;
        st_d.wake = ovf & pdown;
        if (ovf && !pdown) begin
            st_d.to = 1'b1;
        end else if (clr_any) begin
            st_d.to = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign chip_rst_req = st_q.chip;
    assign wake_rst_req = st_q.wake;
    assign to_flag      = st_q.to;

    AST_CHIP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        chip_rst_req |=> !chip_rst_req) else $error("chip request too long"); // R4

    AST_TO_WITH_CHIP: assert property (@(posedge clk) disable iff (!rst_n)
        chip_rst_req |-> to_flag) else $error("status not set"); // R4

    AST_WAKE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        wake_rst_req |=> !wake_rst_req) else $error("wake request too long"); // R5

    AST_ONE_KIND: assert property (@(posedge clk) disable iff (!rst_n)
        !(chip_rst_req && wake_rst_req)) else $error("both requests"); // R5

    AST_WAKE_KEEPS_TO: assert property (@(posedge clk) disable iff (!rst_n)
        wake_rst_req |-> (to_flag == $past(to_flag))) else $error("status moved on wake"); // R5

    AST_TO_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (to_flag && !clr_any) |=> to_flag) else $error("status dropped"); // R6

    AST_CLR_BEATS: assert property (@(posedge clk) disable iff (!rst_n)
        clr_any |=> (!chip_rst_req && !wake_rst_req)) else $error("request despite clear"); // R11

endmodule

// File: tb/wdog_core_test.sv
`timescale 1ns/1ps
module wdog_core_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       osc_tick = 1'b1;
    logic       src_sel = 1'b1;
    logic       pair_mode = 1'b0;
    logic       clr_one = 1'b0;
    logic       clr_a = 1'b0;
    logic       clr_b = 1'b0;
    logic       halt = 1'b0;
    logic       pdown = 1'b0;
    logic [2:0] per_sel = 3'd0;
    logic       chip_rst_req, wake_rst_req, to_flag;

    int cyc = 0;
    int n_chk = 0;
    int n_bad = 0;
    int ref_c = 0;

    wdog_core uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .osc_tick     (osc_tick),
        .src_sel      (src_sel),
        .pair_mode    (pair_mode),
        .clr_one      (clr_one),
        .clr_a        (clr_a),
        .clr_b        (clr_b),
        .halt         (halt),
        .pdown        (pdown),
        .per_sel      (per_sel),
        .chip_rst_req (chip_rst_req),
        .wake_rst_req (wake_rst_req),
        .to_flag      (to_flag)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // called at a negedge; ref_c becomes the edge that sampled the strobe
    task automatic strobe(input int which);
        case (which)
            0: clr_one = 1'b1;
            1: clr_a = 1'b1;
            2: clr_b = 1'b1;
            3: halt = 1'b1;
            default: begin clr_a = 1'b1; clr_b = 1'b1; end
        endcase
        @(negedge clk);
        clr_one = 1'b0; clr_a = 1'b0; clr_b = 1'b0; halt = 1'b0;
        ref_c = cyc;
    endtask

    task automatic go_to(input int t);
        while (cyc < t) @(negedge clk);
    endtask

    task automatic wait_pulse(input int limit, output int at);
        at = -1;
        for (int i = 0; i < limit; i++) begin
            @(negedge clk);
            if (chip_rst_req || wake_rst_req) begin
                at = cyc;
                break;
            end
        end
    endtask

    task automatic apply_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 chip_rst_req in reset", int'(chip_rst_req), 0);
        chk("R1 wake_rst_req in reset", int'(wake_rst_req), 0);
        chk("R1 to_flag in reset", int'(to_flag), 0);
        rst_n = 1'b1;
        ref_c = cyc;
    endtask

    task automatic run_tests();
        int at, r0, r1;
        @(negedge clk);
        apply_reset();
        wait_pulse(300, at);
        chk("R1 first expiry after reset", at, ref_c + 256);

        // R2 / R4 / R6: sweep every tap with oscillator ticks
        for (int k = 0; k < 8; k++) begin
            per_sel = 3'(k);
            strobe(0);
            chk("R6 to_flag cleared by clear", int'(to_flag), 0);
            r0 = ref_c;
            wait_pulse((256 << k) + 20, at);
            chk("R2 expiry cycle", at - r0, 256 << k);
            chk("R4 chip_rst_req at expiry", int'(chip_rst_req), 1);
            chk("R4 wake_rst_req at expiry", int'(wake_rst_req), 0);
            chk("R4 to_flag at expiry", int'(to_flag), 1);
            @(negedge clk);
            chk("R4 chip_rst_req one cycle", int'(chip_rst_req), 0);
            repeat (20) @(negedge clk);
            chk("R6 to_flag sticky", int'(to_flag), 1);
        end

        // R3: divided system clock
        src_sel = 1'b0;
        for (int k = 0; k < 2; k++) begin
            per_sel = 3'(k);
            strobe(0);
            r0 = ref_c;
            wait_pulse((1024 << k) + 20, at);
            chk("R3 expiry cycle sysdiv", at - r0, 1024 << k);
        end
        src_sel = 1'b1;
        per_sel = 3'd0;

        // R5: power-down expiry
        strobe(0);
        r0 = ref_c;
        wait_pulse(300, at);
        chk("R4 expiry before power-down", at - r0, 256);
        pdown = 1'b1;
        wait_pulse(300, at);
        chk("R5 wake expiry cycle", at - r0, 512);
        chk("R5 wake_rst_req set", int'(wake_rst_req), 1);
        chk("R5 chip_rst_req quiet", int'(chip_rst_req), 0);
        chk("R5 to_flag kept", int'(to_flag), 1);
        @(negedge clk);
        chk("R5 wake one cycle", int'(wake_rst_req), 0);
        pdown = 1'b0;

        // R7: single style
        strobe(0);
        r0 = ref_c;
        go_to(r0 + 100);
        strobe(1);
        strobe(2);
        wait_pulse(300, at);
        chk("R7 paired strobes ignored", at - r0, 256);
        strobe(0);
        r0 = ref_c;
        go_to(r0 + 200);
        strobe(0);
        r1 = ref_c;
        wait_pulse(300, at);
        chk("R7 mid-run clear restarts", at - r1, 256);

        // R11: clear on the expiry edge
        strobe(0);
        r0 = ref_c;
        go_to(r0 + 255);
        strobe(0);
        chk("R11 no request on clear edge", int'(chip_rst_req | wake_rst_req), 0);
        r1 = ref_c;
        wait_pulse(300, at);
        chk("R11 full period after", at - r1, 256);

        // R8: paired style
        pair_mode = 1'b1;
        strobe(1);
        strobe(2);
        r0 = ref_c;
        go_to(r0 + 100);
        strobe(0);
        wait_pulse(300, at);
        chk("R8 single strobe ignored", at - r0, 256);
        strobe(1);
        go_to(ref_c + 30);
        strobe(2);
        r0 = ref_c;
        wait_pulse(300, at);
        chk("R8 a then b", at - r0, 256);
        strobe(2);
        go_to(ref_c + 30);
        strobe(1);
        r0 = ref_c;
        wait_pulse(300, at);
        chk("R8 b then a", at - r0, 256);
        strobe(4);
        r0 = ref_c;
        wait_pulse(300, at);
        chk("R8 same cycle", at - r0, 256);

        // R9: repeats
        strobe(4);
        r0 = ref_c;
        go_to(r0 + 40);
        strobe(1);
        go_to(r0 + 80);
        strobe(1);
        wait_pulse(300, at);
        chk("R9 repeated a", at - r0, 256);
        strobe(2);
        r1 = ref_c;
        wait_pulse(300, at);
        chk("R8 b completes pending a", at - r1, 256);
        strobe(4);
        r0 = ref_c;
        go_to(r0 + 40);
        strobe(2);
        go_to(r0 + 80);
        strobe(2);
        wait_pulse(300, at);
        chk("R9 repeated b", at - r0, 256);
        strobe(1);
        r0 = ref_c;
        wait_pulse(300, at);
        chk("R8 a completes pending b", at - r0, 256);

        // R10: halt
        strobe(1);
        go_to(ref_c + 20);
        strobe(3);
        chk("R10 halt clears to_flag", int'(to_flag), 0);
        r0 = ref_c;
        go_to(r0 + 30);
        strobe(2);
        wait_pulse(300, at);
        chk("R10 flag dropped by halt", at - r0, 256);

        // R1: reset in mid-run
        go_to(cyc + 50);
        apply_reset();
        r0 = ref_c;
        wait_pulse(300, at);
        chk("R1 expiry after mid-run reset", at - r0, 256);
    endtask

    initial begin
        fork
            run_tests();
            begin
                repeat (190000) @(posedge clk);
                n_chk++;
                n_bad++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        disable fork;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule